// File: doc/BRIEF.md
# Strap-Sampled Frequency Select with Shared-Pin Direction Control

This block owns a small group of pads that play two roles. While the synchronous power-on reset is held, the pads are inputs: their drivers stay off and the level on each pad is sampled on every clock. A pad that nothing drives externally reads as logic 1, which models the internal pull-up. The sample taken at the last clock edge of reset is frozen into a strap latch. From then on the pads become outputs that carry the clocks presented on `clk_src`.

The block also supplies the five-bit frequency code to the clock generation logic. By default after reset the code is the latched strap value. A control byte can be written to switch the source to a code held in a register field, and a later write can switch it back. The frozen strap bits stay visible on a read port, so software can see the hardware selection.

Top module: `fsel_strap_top`

## Requirements
- R1: While `rst` is high, after each clock edge `pin_oe` is all zeros and `pin_out` is all zeros, whatever `clk_src` carries.
- R2: `strap_rd` equals the pad levels sampled at the last clock edge at which `rst` was high. For each bit the sampled level is 1 when `pin_undriven` is 1, and otherwise it is `pin_lvl`.
- R3: After the first clock edge at which `rst` is low, `pin_oe` is all ones and `pin_out` equals `clk_src` bit for bit.
- R4: After reset, changes on `pin_lvl` and `pin_undriven` never alter `strap_rd` or `freq_code`.
- R5: From the first clock edge after reset until a control write selects the register source, `freq_code` equals `strap_rd`.
- R6: A write (`cfg_wr` high at a clock edge) with `cfg_byte[3]`=1 selects the register source. The register code is {`cfg_byte[7:4]`, `cfg_byte[2]`}, so code bit 0 comes from byte bit 2 and code bits 4:1 come from byte bits 7:4. `freq_code` shows this code after the following clock edge.
- R7: A write with `cfg_byte[3]`=0 brings `freq_code` back to `strap_rd` after the following clock edge. Byte bits 1:0 have no effect on `freq_code`.
- R8: A new reset sets the source back to the straps, whatever was written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_lvl | input | 5 | Level seen on each shared pad |
| pin_undriven | input | 5 | 1 when nothing drives the pad externally, so the pull-up sets it to 1 |
| clk_src | input | 5 | Clocks to drive onto the pads after reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_byte | input | 8 | Control byte: bit 3 selects the source, bits 7:4 and bit 2 hold the code |
| pin_oe | output | 5 | Pad driver enable |
| pin_out | output | 5 | Pad output value |
| strap_rd | output | 5 | Frozen strap value |
| freq_code | output | 5 | Active frequency code |

## Verification
The driver enable and the strap latch each go through one register. Their results are therefore due right after the first clock edge with reset low, and the bench samples them on the falling edge that follows. A control write goes through two registers: the mode and code register at the write edge, then the output code register at the next edge. So `freq_code` is due one full clock after the write edge. The bench releases the strobe on the falling edge in between and samples only on the falling edge after that second edge. The check that pad changes are ignored wiggles the pads for several cycles after reset and then reads the latch and the code at the ports.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int STRAP_W  = 5;
    localparam int CTL_W    = 8;
    localparam int SRC_BIT  = 3;
    localparam int LOW_BIT  = 2;
    localparam int HIGH_LSB = 4;

    typedef logic [STRAP_W-1:0] fcode_t;

    typedef enum logic {
        SRC_STRAP = 1'b0,
        SRC_REG   = 1'b1
    } fsrc_e;

    typedef struct packed {
        fsrc_e  src;
        fcode_t code;
    } fsel_cfg_t;

    // Split a control byte into source select and register code.
    function automatic fsel_cfg_t decode_ctl(input logic [CTL_W-1:0] b);
        fsel_cfg_t c;
        c.src  = fsrc_e'(b[SRC_BIT]);
        c.code = {b[HIGH_LSB +: STRAP_W-1], b[LOW_BIT]};
        return c;
    endfunction

    // Level seen on a pad with an internal pull-up.
    function automatic logic pad_level(input logic lvl, input logic undriven);
        return undriven | lvl;
    endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
    parameter int W = fsel_pkg::STRAP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_lvl,
    input  logic [W-1:0] pin_undriven,
    output logic [W-1:0] strap_q
);
    // Each bit follows its pad while reset is held and freezes afterwards.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= fsel_pkg::pad_level(pin_lvl[i], pin_undriven[i]);
            end
        end
        assign strap_q[i] = bit_q;
    end
endmodule

// File: rtl/fsel_pad_dir.sv
module fsel_pad_dir #(
    parameter int W = fsel_pkg::STRAP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] clk_src,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out
);
    // One enable flop per pad, so each driver has its own enable.
    for (genvar i = 0; i < W; i++) begin : g_pad
        logic oe_q;
        always_ff @(posedge clk) begin
            if (rst) oe_q <= 1'b0;
            else     oe_q <= 1'b1;
        end
        assign pin_oe[i]  = oe_q;
        assign pin_out[i] = oe_q & clk_src[i];
    end
endmodule

// File: rtl/fsel_code_sel.sv
module fsel_code_sel
    import fsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_byte,
    input  fcode_t           strap_q,
    output fcode_t           freq_code
);
    fsel_cfg_t cfg_q;
    fcode_t    code_q;

    // Write register: the source select and the code are held together.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.src  <= SRC_STRAP;
            cfg_q.code <= '0;
        end else if (cfg_wr) begin
            cfg_q <= decode_ctl(cfg_byte);
        end
    end

    // Output register: changes reach the clock logic one cycle after the write.
    always_ff @(posedge clk) begin
        if (rst)                      code_q <= '0;
        else if (cfg_q.src == SRC_REG) code_q <= cfg_q.code;
        else                          code_q <= strap_q;
    end

    assign freq_code = code_q;
endmodule

// File: rtl/fsel_strap_top.sv
module fsel_strap_top
    import fsel_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STRAP_W-1:0]  pin_lvl,
    input  logic [STRAP_W-1:0]  pin_undriven,
    input  logic [STRAP_W-1:0]  clk_src,
    input  logic                cfg_wr,
    input  logic [CTL_W-1:0]    cfg_byte,
    output logic [STRAP_W-1:0]  pin_oe,
    output logic [STRAP_W-1:0]  pin_out,
    output logic [STRAP_W-1:0]  strap_rd,
    output logic [STRAP_W-1:0]  freq_code
);
    fcode_t strap_q;

    fsel_strap_latch #(.W(STRAP_W)) u_latch (
        .clk(clk), .rst(rst),
        .pin_lvl(pin_lvl), .pin_undriven(pin_undriven),
        .strap_q(strap_q)
    );

    fsel_pad_dir #(.W(STRAP_W)) u_pad (
        .clk(clk), .rst(rst), .clk_src(clk_src),
        .pin_oe(pin_oe), .pin_out(pin_out)
    );

    fsel_code_sel u_sel (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .strap_q(strap_q), .freq_code(freq_code)
    );

    assign strap_rd = strap_q;
endmodule

// File: rtl/fsel_strap_chk.sv
module fsel_strap_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] pin_oe,
    input logic [4:0] pin_out,
    input logic [4:0] strap_rd,
    input logic [4:0] freq_code,
    input logic       cfg_wr,
    input logic [7:0] cfg_byte
);
    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: drivers stay off while reset is held
    always_ff @(posedge clk) begin
        if (rst_d) begin
            assert_oe_off_R1: assert (pin_oe == 5'b0 && pin_out == 5'b0);
        end
    end

    // R3: drivers enabled once reset is gone
    assert_oe_on_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pin_oe == 5'h1f);

    // R4: strap latch frozen after reset
    assert_strap_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_rd));

    // R6: register source shows the written code one clock later
    assert_reg_code_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_byte[3]) ##1 !cfg_wr |=>
        freq_code == {$past(cfg_byte[7:4], 2), $past(cfg_byte[2], 2)});

    // R7: strap source restored one clock after the write
    assert_strap_src_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_byte[3]) ##1 !cfg_wr |=> freq_code == strap_rd);
endmodule

bind fsel_strap_top fsel_strap_chk u_chk (
    .clk(clk), .rst(rst), .pin_oe(pin_oe), .pin_out(pin_out),
    .strap_rd(strap_rd), .freq_code(freq_code),
    .cfg_wr(cfg_wr), .cfg_byte(cfg_byte)
);

// File: tb/fsel_strap_top_tb.sv
module fsel_strap_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] pin_lvl = '0, pin_undriven = '0, clk_src = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_byte = '0;
    logic [4:0] pin_oe, pin_out, strap_rd, freq_code;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    fsel_strap_top u_dut (
        .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .pin_undriven(pin_undriven),
        .clk_src(clk_src), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
        .pin_oe(pin_oe), .pin_out(pin_out), .strap_rd(strap_rd), .freq_code(freq_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Hold reset for three edges with the given pads; returns after the
    // first edge with reset low, on a falling edge.
    task automatic do_reset(input logic [4:0] lvl, input logic [4:0] und);
        @(negedge clk);
        rst = 1'b1; pin_lvl = lvl; pin_undriven = und; clk_src = 5'h1f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 oe in reset", {3'b0, pin_oe}, 8'h00);
        check("R1 out in reset", {3'b0, pin_out}, 8'h00);
        rst = 1'b0;
        pin_lvl = ~lvl; pin_undriven = 5'h00;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_ctl(input logic [7:0] b);
        cfg_wr = 1'b1; cfg_byte = b;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_byte = ~b;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // Strap sweep over all levels with a varying undriven mask
        for (int c = 0; c < 32; c++) begin
            logic [4:0] lvl, und, exp_s;
            lvl = 5'(c);
            und = 5'((c * 7) >> 2) & 5'h15;
            exp_s = lvl | und;
            do_reset(lvl, und);
            check("R2 strap", {3'b0, strap_rd}, {3'b0, exp_s});
            check("R3 oe", {3'b0, pin_oe}, 8'h1f);
            clk_src = 5'(c ^ 5'h0a);
            #1;
            check("R3 out", {3'b0, pin_out}, {3'b0, 5'(c ^ 5'h0a)});
            check("R5 default src", {3'b0, freq_code}, {3'b0, exp_s});
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                pin_lvl = 5'(c + k * 9); pin_undriven = 5'(k * 11);
            end
            @(negedge clk);
            check("R4 strap held", {3'b0, strap_rd}, {3'b0, exp_s});
            check("R4 code held", {3'b0, freq_code}, {3'b0, exp_s});
        end

        // Register source sweep over all codes, with bits 1:0 varying
        do_reset(5'h13, 5'h00);
        for (int c = 0; c < 32; c++) begin
            logic [7:0] b;
            b = {4'(c >> 1), 1'b1, 1'(c), 2'(c * 3)};
            write_ctl(b);
            check("R6 reg code", {3'b0, freq_code}, {3'b0, 5'(c)});
            check("R6 strap unchanged", {3'b0, strap_rd}, 8'h13);
        end

        // Back to straps, with ignored low bits and junk code bits
        write_ctl(8'hf7);
        check("R7 back to strap", {3'b0, freq_code}, 8'h13);
        write_ctl(8'h5e);
        check("R6 reg again", {3'b0, freq_code}, 8'h0b);
        write_ctl(8'ha2);
        check("R7 low bits ignored", {3'b0, freq_code}, 8'h13);

        // New reset returns the source to straps
        write_ctl(8'h98);
        check("R6 before reset", {3'b0, freq_code}, 8'h12);
        do_reset(5'h04, 5'h08);
        check("R8 strap after reset", {3'b0, freq_code}, 8'h0c);
        check("R2 new strap", {3'b0, strap_rd}, 8'h0c);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule